// File: doc/BRIEF.md
# HDLC Frame Receiver

This block takes a bit-serial line, one bit per cycle in which the bit strobe is high, and turns it back into frames. It finds the 0x7E flag pattern that bounds each frame, drops the zero a sender inserts after five ones in a row, and packs the remaining bits into bytes, least significant bit first. It runs a CRC-16 over every byte of the frame, the two check bytes included. It compares the final remainder against a fixed residue to decide whether the frame arrived intact.

The two check bytes are never delivered. The receiver keeps the newest three bytes of a frame in a small holding buffer and releases a byte only once three newer ones are behind it. When the closing flag arrives, the oldest held byte is the last data byte: it goes out marked as last, in the same cycle as the end-of-frame pulse and its status. A frame that ends early, that does not end on a byte boundary, or that is cut off by a run of ones ends with a status code and no last byte. A separate level output reports an idle line, meaning a long run of ones. A downstream FIFO or controller consumes the byte stream and the status.

Top module: `hdlc_rx`

## Requirements
- R1: While reset is asserted and after it is released, `rx_valid`, `frame_done`, `abort_pulse` and `line_idle` are low until line activity changes them.
- R2: The pattern 0, six ones, 0 is a flag. It closes an open frame and opens the next one. A flag that follows another flag with no data between them produces no output at all.
- R3: Inside a frame, a zero that directly follows five consecutive ones is removed, so data bytes containing long runs of ones are delivered unchanged.
- R4: Data bits are packed least significant bit first. The first delivered byte of each frame has `rx_first` high, and no other byte does.
- R5: The final 16 bits before the closing flag (the check bytes) are never delivered. The last data byte is delivered with `rx_last` high in the same cycle as `frame_done`.
- R6: The CRC uses x^16 + x^12 + x^5 + 1, starts at all ones, and is run over the data and check bits in arrival order. The sender transmits the complemented CRC, most significant bit first. A remainder of 0x1D0F gives status 00, and any other remainder gives status 01.
- R7: Seven consecutive ones inside a frame that has already received at least one whole byte abort it. This gives `abort_pulse` and `frame_done` with status 10 and no last byte. The same run before any whole byte has arrived ends the frame silently.
- R8: A frame with fewer than four bytes in total (two data plus two check), or whose length is not a whole number of bytes, ends with `frame_done` and status 11 and no last byte.
- R9: `line_idle` goes high on the fifteenth consecutive one and stays high until a flag is received. Fourteen ones leave it low.
- R10: While `bit_en` is low, `bit_in` has no effect on any output or state.
- R11: Every output event appears one clock after the strobe edge that caused it and lasts one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | Bit strobe: `bit_in` is taken in cycles where this is high |
| bit_in | input | 1 | Serial line bit |
| rx_data | output | 8 | Delivered data byte |
| rx_valid | output | 1 | `rx_data` holds a data byte this cycle |
| rx_first | output | 1 | Delivered byte is the first of its frame |
| rx_last | output | 1 | Delivered byte is the last of its frame |
| frame_done | output | 1 | Frame ended this cycle; `frame_status` is valid |
| frame_status | output | 2 | 00 good, 01 bad CRC, 10 aborted, 11 short or misaligned |
| abort_pulse | output | 1 | One-cycle pulse on a frame abort |
| line_idle | output | 1 | Line has shown fifteen or more ones since the last flag |

## Verification
The assertions check relations between outputs on every cycle. A last byte comes only with a good or bad-CRC close, an abort always carries status 10 and no byte, a first byte is never also the last, and events follow a strobe and last one cycle. The idle flag may rise only after a strobed one. Whether the bytes are the right ones can only be shown by the bench scenarios: zero removal, holding back the check bytes, the CRC verdict, where length and alignment boundaries fall, and the exact count of ones at which idle and abort trigger.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  localparam logic [15:0] CRC_POLY    = 16'h1021;
  localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
  localparam logic [15:0] CRC_RESIDUE = 16'h1D0F;

  typedef enum logic [1:0] {
    ST_GOOD  = 2'b00,
    ST_BADCK = 2'b01,
    ST_ABORT = 2'b10,
    ST_SHAPE = 2'b11
  } rx_status_t;

  // Advance the CRC by one byte; bit 0 is the bit that arrived first.
  function automatic logic [15:0] crc_step_byte(input logic [15:0] c_in,
                                                input logic [7:0]  d);
    logic [15:0] c;
    logic        fb;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[15] ^ d[i];
      c  = {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    end
    return c;
  endfunction

endpackage

// File: rtl/hdlc_rx_line.sv
// Classifies each strobed line bit by the run of ones in front of it.
module hdlc_rx_line #(
  parameter int STUFF_RUN = 5,
  parameter int IDLE_RUN  = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bit_in,
  output logic ev_flag,
  output logic ev_data,
  output logic ev_seven,
  output logic line_idle
);

  localparam int FLAG_RUN  = STUFF_RUN + 1;
  localparam int ONES_W    = $clog2(IDLE_RUN + 1);

  logic [ONES_W-1:0] ones_q, ones_d;
  logic              idle_q, idle_d;
  logic              run_stuff, run_flag;

  assign run_stuff = (ones_q == ONES_W'(STUFF_RUN));
  assign run_flag  = (ones_q == ONES_W'(FLAG_RUN));

  always_comb begin
    ev_flag  = bit_en && !bit_in && run_flag;
    ev_seven = bit_en &&  bit_in && run_flag;
    ev_data  = bit_en && (bit_in ? (ones_q < ONES_W'(STUFF_RUN))
                                 : (!run_stuff && !run_flag));
  end

  always_comb begin
    ones_d = ones_q;
    idle_d = idle_q;
    if (bit_en) begin
      if (bit_in) begin
        if (ones_q != ONES_W'(IDLE_RUN)) ones_d = ones_q + 1'b1;
        if (ones_q == ONES_W'(IDLE_RUN - 1)) idle_d = 1'b1;
      end else begin
        ones_d = '0;
        if (run_flag) idle_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= '0;
      idle_q <= 1'b0;
    end else begin
      ones_q <= ones_d;
      idle_q <= idle_d;
    end
  end

  assign line_idle = idle_q;

endmodule

// File: rtl/hdlc_rx_crc.sv
// Byte-wise CRC register, updated once per completed byte.
module hdlc_rx_crc
  import hdlc_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        crc_clr,
  input  logic        crc_upd,
  input  logic [7:0]  crc_din,
  output logic [15:0] crc_val
);

  logic [15:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (crc_clr)      crc_d = CRC_PRESET;
    else if (crc_upd) crc_d = crc_step_byte(crc_q, crc_din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_PRESET;
    else        crc_q <= crc_d;
  end

  assign crc_val = crc_q;

endmodule

// File: rtl/hdlc_rx_frame.sv
// Frame tracking, byte packing, holding buffer and end-of-frame verdict.
module hdlc_rx_frame
  import hdlc_rx_pkg::*;
#(
  parameter int FCS_BYTES  = 2,
  parameter int MIN_DATA   = 2,
  parameter int FLAG_TAIL  = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_flag,
  input  logic        ev_data,
  input  logic        ev_seven,
  input  logic        bit_in,
  input  logic [15:0] crc_val,
  output logic        crc_clr,
  output logic        crc_upd,
  output logic [7:0]  crc_din,
  output logic [7:0]  rx_data,
  output logic        rx_valid,
  output logic        rx_first,
  output logic        rx_last,
  output logic        frame_done,
  output logic [1:0]  frame_status,
  output logic        abort_pulse
);

  localparam int HOLD_BYTES = FCS_BYTES + 1;
  localparam int MIN_BYTES  = MIN_DATA + FCS_BYTES;
  localparam int HC_W       = $clog2(HOLD_BYTES + 1);
  localparam int NB_W       = $clog2(MIN_BYTES + 1);

  logic              in_frame_q, in_frame_d;
  logic [2:0]        accn_q, accn_d;
  logic [7:0]        acc_q, acc_d;
  logic [7:0]        hold_q [HOLD_BYTES];
  logic [7:0]        hold_d [HOLD_BYTES];
  logic [HC_W-1:0]   hcnt_q, hcnt_d;
  logic [NB_W-1:0]   nbyte_q, nbyte_d;
  logic              fpend_q, fpend_d;

  logic              valid_q, valid_d;
  logic              first_q, first_d;
  logic              last_q, last_d;
  logic              done_q, done_d;
  logic              abort_q, abort_d;
  logic [1:0]        status_q, status_d;
  logic [7:0]        data_q, data_d;

  logic [7:0]        new_byte;
  logic              frame_empty, shape_bad;

  assign new_byte    = {bit_in, acc_q[7:1]};
  assign frame_empty = (nbyte_q == '0) && (accn_q == 3'(FLAG_TAIL));
  assign shape_bad   = (accn_q != 3'(FLAG_TAIL)) || (nbyte_q < NB_W'(MIN_BYTES));
  assign crc_din     = new_byte;

  always_comb begin
    in_frame_d = in_frame_q;
    accn_d     = accn_q;
    acc_d      = acc_q;
    hold_d     = hold_q;
    hcnt_d     = hcnt_q;
    nbyte_d    = nbyte_q;
    fpend_d    = fpend_q;
    valid_d    = 1'b0;
    first_d    = 1'b0;
    last_d     = 1'b0;
    done_d     = 1'b0;
    abort_d    = 1'b0;
    status_d   = status_q;
    data_d     = data_q;
    crc_clr    = 1'b0;
    crc_upd    = 1'b0;

    if (ev_flag) begin
      if (in_frame_q && !frame_empty) begin
        done_d = 1'b1;
        if (shape_bad) begin
          status_d = ST_SHAPE;
        end else begin
          valid_d  = 1'b1;
          last_d   = 1'b1;
          first_d  = fpend_q;
          data_d   = hold_q[0];
          status_d = (crc_val == CRC_RESIDUE) ? ST_GOOD : ST_BADCK;
        end
      end
      in_frame_d = 1'b1;
      accn_d     = '0;
      hcnt_d     = '0;
      nbyte_d    = '0;
      fpend_d    = 1'b1;
      crc_clr    = 1'b1;
    end else if (ev_seven && in_frame_q) begin
      if (nbyte_q != '0) begin
        done_d   = 1'b1;
        abort_d  = 1'b1;
        status_d = ST_ABORT;
      end
      in_frame_d = 1'b0;
    end else if (ev_data && in_frame_q) begin
      acc_d  = new_byte;
      accn_d = accn_q + 1'b1;
      if (accn_q == 3'd7) begin
        crc_upd = 1'b1;
        if (nbyte_q != NB_W'(MIN_BYTES)) nbyte_d = nbyte_q + 1'b1;
        if (hcnt_q == HC_W'(HOLD_BYTES)) begin
          valid_d = 1'b1;
          data_d  = hold_q[0];
          first_d = fpend_q;
          fpend_d = 1'b0;
          for (int k = 0; k < HOLD_BYTES - 1; k++) hold_d[k] = hold_q[k+1];
          hold_d[HOLD_BYTES-1] = new_byte;
        end else begin
          hold_d[hcnt_q] = new_byte;
          hcnt_d         = hcnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      accn_q     <= '0;
      hcnt_q     <= '0;
      nbyte_q    <= '0;
      fpend_q    <= 1'b1;
      valid_q    <= 1'b0;
      first_q    <= 1'b0;
      last_q     <= 1'b0;
      done_q     <= 1'b0;
      abort_q    <= 1'b0;
      status_q   <= ST_GOOD;
    end else begin
      in_frame_q <= in_frame_d;
      accn_q     <= accn_d;
      hcnt_q     <= hcnt_d;
      nbyte_q    <= nbyte_d;
      fpend_q    <= fpend_d;
      valid_q    <= valid_d;
      first_q    <= first_d;
      last_q     <= last_d;
      done_q     <= done_d;
      abort_q    <= abort_d;
      status_q   <= status_d;
    end
  end

  // Datapath registers carry no reset; they are qualified by the flags above.
  always_ff @(posedge clk) begin
    acc_q  <= acc_d;
    hold_q <= hold_d;
    data_q <= data_d;
  end

  assign rx_data      = data_q;
  assign rx_valid     = valid_q;
  assign rx_first     = first_q;
  assign rx_last      = last_q;
  assign frame_done   = done_q;
  assign frame_status = status_q;
  assign abort_pulse  = abort_q;

endmodule

// File: rtl/hdlc_rx.sv
module hdlc_rx #(
  parameter int STUFF_RUN = 5,
  parameter int IDLE_RUN  = 15,
  parameter int FCS_BYTES = 2,
  parameter int MIN_DATA  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       bit_in,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_first,
  output logic       rx_last,
  output logic       frame_done,
  output logic [1:0] frame_status,
  output logic       abort_pulse,
  output logic       line_idle
);

  localparam int FLAG_TAIL = STUFF_RUN + 1;

  logic [1:0]  rst_pipe;
  logic        rst_sync_n;
  logic        ev_flag, ev_data, ev_seven;
  logic        crc_clr, crc_upd;
  logic [7:0]  crc_din;
  logic [15:0] crc_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  hdlc_rx_line #(
    .STUFF_RUN (STUFF_RUN),
    .IDLE_RUN  (IDLE_RUN)
  ) line_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bit_en    (bit_en),
    .bit_in    (bit_in),
    .ev_flag   (ev_flag),
    .ev_data   (ev_data),
    .ev_seven  (ev_seven),
    .line_idle (line_idle)
  );

  hdlc_rx_crc crc_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .crc_clr (crc_clr),
    .crc_upd (crc_upd),
    .crc_din (crc_din),
    .crc_val (crc_val)
  );

  hdlc_rx_frame #(
    .FCS_BYTES (FCS_BYTES),
    .MIN_DATA  (MIN_DATA),
    .FLAG_TAIL (FLAG_TAIL)
  ) frame_i (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .ev_flag      (ev_flag),
    .ev_data      (ev_data),
    .ev_seven     (ev_seven),
    .bit_in       (bit_in),
    .crc_val      (crc_val),
    .crc_clr      (crc_clr),
    .crc_upd      (crc_upd),
    .crc_din      (crc_din),
    .rx_data      (rx_data),
    .rx_valid     (rx_valid),
    .rx_first     (rx_first),
    .rx_last      (rx_last),
    .frame_done   (frame_done),
    .frame_status (frame_status),
    .abort_pulse  (abort_pulse)
  );

endmodule

// File: rtl/hdlc_rx_chk.sv
module hdlc_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_en,
  input logic       bit_in,
  input logic       rx_valid,
  input logic       rx_first,
  input logic       rx_last,
  input logic       frame_done,
  input logic [1:0] frame_status,
  input logic       abort_pulse,
  input logic       line_idle
);

  p_event_after_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid || frame_done) |-> $past(bit_en));

  p_done_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  p_last_closes_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_last |-> (rx_valid && frame_done && !frame_status[1]));

  p_first_not_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_first |-> (rx_valid && !rx_last));

  p_abort_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> (frame_done && frame_status == 2'b10 && !rx_valid));

  p_shape_no_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && frame_status == 2'b11) |-> !rx_valid);

  p_idle_after_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_idle) |-> $past(bit_en && bit_in));

endmodule

bind hdlc_rx hdlc_rx_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .bit_en       (bit_en),
  .bit_in       (bit_in),
  .rx_valid     (rx_valid),
  .rx_first     (rx_first),
  .rx_last      (rx_last),
  .frame_done   (frame_done),
  .frame_status (frame_status),
  .abort_pulse  (abort_pulse),
  .line_idle    (line_idle)
);

// File: tb/hdlc_rx_tb_top.sv
`timescale 1ns/1ps
module hdlc_rx_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       bit_in = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, rx_first, rx_last, frame_done, abort_pulse, line_idle;
  logic [1:0] frame_status;

  hdlc_rx dut_i (
    .clk (clk), .rst_n (rst_n), .bit_en (bit_en), .bit_in (bit_in),
    .rx_data (rx_data), .rx_valid (rx_valid), .rx_first (rx_first),
    .rx_last (rx_last), .frame_done (frame_done), .frame_status (frame_status),
    .abort_pulse (abort_pulse), .line_idle (line_idle)
  );

  always #4 clk = ~clk;

  typedef struct {
    bit       valid;
    bit [7:0] data;
    bit       first;
    bit       last;
    bit       done;
    bit [1:0] status;
    bit       abort;
    string    req;
  } exp_t;

  exp_t       sb_q[$];
  bit   [7:0] pay[$];
  int         total = 0;
  int         bad = 0;
  bit         live = 1'b0;
  bit         finished = 1'b0;
  int         ones_run = 0;
  bit  [15:0] tb_crc;

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void push_byte(bit [7:0] d, bit first, string req);
    exp_t e;
    e.valid = 1; e.data = d; e.first = first; e.last = 0;
    e.done = 0; e.status = 0; e.abort = 0; e.req = req;
    sb_q.push_back(e);
  endfunction

  function automatic void push_close(bit [7:0] d, bit [1:0] st, string req);
    exp_t e;
    e.valid = 1; e.data = d; e.first = 0; e.last = 1;
    e.done = 1; e.status = st; e.abort = 0; e.req = req;
    sb_q.push_back(e);
  endfunction

  function automatic void push_done(bit [1:0] st, bit ab, string req);
    exp_t e;
    e.valid = 0; e.data = 0; e.first = 0; e.last = 0;
    e.done = 1; e.status = st; e.abort = ab; e.req = req;
    sb_q.push_back(e);
  endfunction

  // Monitor: pops one expected event per observed output event.
  always @(negedge clk) begin
    if (live && (rx_valid || frame_done || abort_pulse)) begin
      exp_t e;
      int   act, exp;
      if (sb_q.size() == 0) begin
        check(0, "R2", "unexpected output event", {rx_valid, frame_done, abort_pulse}, 0);
      end else begin
        e   = sb_q.pop_front();
        act = {rx_valid, (rx_valid ? rx_data : 8'h00), rx_first, rx_last,
               frame_done, (frame_done ? frame_status : 2'b00), abort_pulse};
        exp = {e.valid, e.data, e.first, e.last, e.done, e.status, e.abort};
        check(act == exp, e.req, "output event", act, exp);
      end
    end
  end

  // One strobed bit, followed by a cycle with the strobe low and junk on the line (R10).
  task automatic drive_raw(input bit b);
    @(negedge clk);
    bit_en = 1'b1;
    bit_in = b;
    @(negedge clk);
    bit_en = 1'b0;
    bit_in = ~b;
  endtask

  task automatic send_flag();
    drive_raw(1'b0);
    repeat (6) drive_raw(1'b1);
    drive_raw(1'b0);
    ones_run = 0;
  endtask

  task automatic send_stuffed(input bit b);
    drive_raw(b);
    if (b) begin
      ones_run++;
      if (ones_run == 5) begin
        drive_raw(1'b0);   // inserted zero, removed by the receiver (R3)
        ones_run = 0;
      end
    end else begin
      ones_run = 0;
    end
  endtask

  function automatic void crc_bit(input bit b);
    bit fb;
    fb     = tb_crc[15] ^ b;
    tb_crc = {tb_crc[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
  endfunction

  task automatic send_body();
    foreach (pay[j]) begin
      for (int i = 0; i < 8; i++) begin
        send_stuffed(pay[j][i]);
        crc_bit(pay[j][i]);
      end
    end
  endtask

  task automatic send_frame(input bit corrupt, input int extra, input bit auto_exp);
    bit [15:0] fcs;
    int n;
    n = pay.size();
    if (auto_exp) begin
      if (n >= 2) begin
        for (int i = 0; i < n - 1; i++) push_byte(pay[i], i == 0, "R4");
        push_close(pay[n-1], corrupt ? 2'b01 : 2'b00, corrupt ? "R6" : "R5");
      end else begin
        push_done(2'b11, 1'b0, "R8");
      end
    end
    send_flag();
    tb_crc = 16'hFFFF;
    send_body();
    fcs = ~tb_crc;
    if (corrupt) fcs[3] = ~fcs[3];
    for (int i = 15; i >= 0; i--) send_stuffed(fcs[i]);
    for (int i = 0; i < extra; i++) send_stuffed(1'b0);
    send_flag();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check(!rx_valid && !frame_done && !abort_pulse && !line_idle, "R1", "in reset",
          {rx_valid, frame_done, abort_pulse, line_idle}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!rx_valid && !frame_done && !abort_pulse && !line_idle, "R1", "after reset",
          {rx_valid, frame_done, abort_pulse, line_idle}, 0);
    live = 1'b1;

    // R10: ones on the line without the strobe must not raise idle
    bit_in = 1'b1;
    repeat (40) @(negedge clk);
    check(line_idle == 1'b0, "R10", "idle with strobe low", line_idle, 0);
    bit_in = 1'b0;

    // R2: back-to-back flags give no output
    repeat (3) send_flag();

    // R3 R4 R5 R6: good frame with runs of ones inside the data
    pay = '{8'hFF, 8'h7E, 8'h3F, 8'hA5};
    send_frame(1'b0, 0, 1'b1);

    // R8 boundary: two data bytes is the minimum accepted
    pay = '{8'h03, 8'hF0};
    send_frame(1'b0, 0, 1'b1);

    // R6: one check bit flipped gives status 01
    pay = '{8'h12, 8'h34, 8'h56};
    send_frame(1'b1, 0, 1'b1);

    // R8: one data byte is too short
    pay = '{8'hC3};
    send_frame(1'b0, 0, 1'b1);

    // R8: three stray bits make the frame misaligned
    pay = '{8'h01, 8'h80, 8'hFE, 8'h55};
    push_byte(8'h01, 1'b1, "R8");
    push_byte(8'h80, 1'b0, "R8");
    push_byte(8'hFE, 1'b0, "R8");
    push_byte(8'h55, 1'b0, "R8");
    push_done(2'b11, 1'b0, "R8");
    send_frame(1'b0, 3, 1'b0);

    // R7: abort after five bytes
    pay = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    push_byte(8'h11, 1'b1, "R7");
    push_byte(8'h22, 1'b0, "R7");
    push_done(2'b10, 1'b1, "R7");
    send_flag();
    tb_crc = 16'hFFFF;
    send_body();
    drive_raw(1'b0);
    repeat (7) drive_raw(1'b1);
    check(line_idle == 1'b0, "R9", "idle after 7 ones", line_idle, 0);
    repeat (7) drive_raw(1'b1);
    check(line_idle == 1'b0, "R9", "idle after 14 ones", line_idle, 0);
    drive_raw(1'b1);
    check(line_idle == 1'b1, "R9", "idle after 15 ones", line_idle, 1);
    send_flag();
    check(line_idle == 1'b0, "R9", "idle cleared by flag", line_idle, 0);

    // recovery after abort
    pay = '{8'h5A, 8'hC0, 8'h0F};
    send_frame(1'b0, 0, 1'b1);

    // R7: ones right after a flag, before any byte, end silently
    repeat (16) drive_raw(1'b1);
    check(line_idle == 1'b1, "R9", "idle after flag then 16 ones", line_idle, 1);
    send_flag();
    check(line_idle == 1'b0, "R9", "idle cleared again", line_idle, 0);

    // R3: all-ones data needs a stuffed zero in every byte
    pay = '{8'hFF, 8'hFF, 8'hFF};
    send_frame(1'b0, 0, 1'b1);

    repeat (20) @(negedge clk);
    check(sb_q.size() == 0, "R5", "expected events left over", sb_q.size(), 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      check(0, "R11", "watchdog expired", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule